// File: doc/BRIEF.md
# Debug Serial Console Port

This block is an asynchronous serial port meant for a chip's debug console. Software drives it through a small word-addressed register bus. Write-one command bits switch the receiver and transmitter on and off and reset each of them separately. A mode register picks the parity treatment and the way the serial pins are routed. A divisor register sets the bit rate. Received characters land in a holding register, and characters to send are written to a transmit holding register. One interrupt line reports the status flags that software has unmasked.

The bit clock runs at sixteen times the bit rate. That tick comes from dividing the system clock by the divisor, so one bit lasts 16 × divisor clock cycles. The receiver confirms a start bit at its midpoint and samples every later bit at its centre. The error flags (overrun, framing, parity, break) are sticky. Only the clear-errors command resets them. Four routings let the port loop its own output back internally, echo the incoming line, or wire the pins straight through for remote testing.

Top module: `dbg_uart`

## Requirements
- R1: After reset both directions are off, `txd` is 1 and every status bit reads 0. In the CTRL register (address 0), bit 2 turns the receiver on, bit 3 turns it off, bit 4 turns the transmitter on and bit 5 turns it off. When on and off are written together, off wins. Bit 0 resets the receiver and clears the ready flag. Bit 1 resets the transmitter. A disabled transmitter ignores writes to TXHOLD and keeps `txd` at 1. A disabled receiver takes in no characters.
- R2: DIV (address 2) holds the divisor CD. Each serial bit lasts 16·CD clock cycles. CD = 0 stops all transfers, and a waiting character stays in the holding register.
- R3: A transmitted frame is a 0 start bit, eight data bits LSB first, an optional parity bit, and one stop bit at 1.
- R4: MODE (address 1) bits [2:0] select the parity: 0 none, 1 even, 2 odd, 3 always 0, 4 always 1, 5 multidrop. Codes 6 and 7 behave as none.
- R5: In multidrop mode the parity slot carries bit 8 of TXHOLD (address 4). On receive, that slot appears as bit 8 of RXHOLD (address 3), and no parity error is raised.
- R6: STATUS (address 7) bit 1 (tx ready) is 1 when the transmitter is on and its holding register is empty. Bit 6 (tx empty) is 1 only when, in addition, no frame is being shifted out.
- R7: STATUS bit 0 (rx ready) is set when a character is placed in RXHOLD. A read of RXHOLD clears it.
- R8: STATUS bit 3 (overrun) is set when a character completes while rx ready is still 1. The new character replaces the old one.
- R9: STATUS bit 4 (framing error) is set when the stop bit samples 0 and the data bits are not all zero.
- R10: STATUS bit 5 (parity error) is set when a received parity bit does not match the selected even, odd, always-0 or always-1 rule.
- R11: STATUS bit 2 (break) is set when a whole frame, stop bit included, samples 0. No character is delivered. The bit is set again when the line returns high. CTRL bit 6 clears bits 2 to 5, and nothing else clears them.
- R12: A low pulse shorter than half a bit on the receive input is ignored.
- R13: MODE bits [5:4] select the routing. 0 is normal. 1 is echo: `rxd` is copied to `txd` and is also received. 2 is local loopback: the transmitter feeds the receiver and `txd` stays 1. 3 is remote loopback: `rxd` is copied to `txd` and the receiver sees an idle line.
- R14: `irq` is the OR of the STATUS bits ANDed with a mask. A write to address 5 sets mask bits and a write to address 6 clears them. A read of address 5 returns the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (has side effects on RXHOLD) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| rxd | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the divisor edge cases. A zero divisor must freeze the transmitter with the character still held. A wrong bit length shows up as a start bit that is not exactly 16·CD cycles long. It also checks that a break cleared while the line is still low comes back when the line rises. A design that only flagged entry into break would leave the bit at 0. Overrun is tested with two back-to-back unread frames, and a glitch of a quarter bit is applied to the receive input. A receiver that did not re-check the start bit at its midpoint would deliver a spurious character. Each routing mode is tested at the pins: a wrong multiplexer leaks loopback traffic onto `txd` or hands the receiver data it should not see.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;

    localparam int BUS_W = 16;
    localparam int ST_W  = 7;

    // register word addresses
    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_MODE = 3'd1;
    localparam logic [2:0] ADR_DIV  = 3'd2;
    localparam logic [2:0] ADR_RXH  = 3'd3;
    localparam logic [2:0] ADR_TXH  = 3'd4;
    localparam logic [2:0] ADR_IEN  = 3'd5;
    localparam logic [2:0] ADR_IDIS = 3'd6;
    localparam logic [2:0] ADR_STAT = 3'd7;

    // command bits
    localparam int CMD_RX_RST = 0;
    localparam int CMD_TX_RST = 1;
    localparam int CMD_RX_ON  = 2;
    localparam int CMD_RX_OFF = 3;
    localparam int CMD_TX_ON  = 4;
    localparam int CMD_TX_OFF = 5;
    localparam int CMD_CLR    = 6;

    // status bits
    localparam int ST_RXRDY = 0;
    localparam int ST_TXRDY = 1;
    localparam int ST_BRK   = 2;
    localparam int ST_OVR   = 3;
    localparam int ST_FRM   = 4;
    localparam int ST_PAR   = 5;
    localparam int ST_TXEMP = 6;

    // parity selection
    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_EVEN  = 3'd1;
    localparam logic [2:0] PAR_ODD   = 3'd2;
    localparam logic [2:0] PAR_SPACE = 3'd3;
    localparam logic [2:0] PAR_MARK  = 3'd4;
    localparam logic [2:0] PAR_DROP  = 3'd5;

    // pin routing
    localparam logic [1:0] CH_NORMAL = 2'd0;
    localparam logic [1:0] CH_ECHO   = 2'd1;
    localparam logic [1:0] CH_LOCAL  = 2'd2;
    localparam logic [1:0] CH_REMOTE = 2'd3;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_START,
        LS_DATA,
        LS_PAR,
        LS_STOP,
        LS_BRK
    } lstate_e;

    function automatic logic par_slot_used(input logic [2:0] m);
        return (m >= PAR_EVEN) && (m <= PAR_DROP);
    endfunction

    function automatic logic par_checked(input logic [2:0] m);
        return (m >= PAR_EVEN) && (m <= PAR_MARK);
    endfunction

endpackage

// File: rtl/dbg_uart_baud.sv
module dbg_uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (div == '0) begin
            d.cnt  = '0;
            d.tick = 1'b0;
        end else if (q.cnt >= div - 1'b1) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt  = q.cnt + 1'b1;
            d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;
endmodule

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
    import dbg_uart_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          soft_rst,
    input  logic          tick,
    input  logic [2:0]    par_mode,
    input  logic          wr,
    input  logic [DW:0]   wdata,
    output logic          line,
    output logic          hold_full,
    output logic          busy
);
    localparam int BW = $clog2(DW);

    typedef struct packed {
        lstate_e       state;
        logic [3:0]    sub;
        logic [BW-1:0] bitn;
        logic [DW-1:0] shift;
        logic          pbit;
        logic [DW:0]   hold;
        logic          hold_v;
        logic          line;
    } st_t;

    st_t q, d;
    logic par_calc;

    always_comb begin
        case (par_mode)
            PAR_EVEN:  par_calc = ^q.hold[DW-1:0];
            PAR_ODD:   par_calc = ~^q.hold[DW-1:0];
            PAR_MARK:  par_calc = 1'b1;
            PAR_DROP:  par_calc = q.hold[DW];
            default:   par_calc = 1'b0;
        endcase
    end

    always_comb begin
        d = q;
        if (!en || soft_rst) begin
            d.state  = LS_IDLE;
            d.sub    = '0;
            d.hold_v = 1'b0;
            d.line   = 1'b1;
        end else begin
            if (tick) begin
                case (q.state)
                    LS_IDLE: begin
                        if (q.hold_v) begin
                            d.shift  = q.hold[DW-1:0];
                            d.pbit   = par_calc;
                            d.hold_v = 1'b0;
                            d.state  = LS_START;
                            d.sub    = '0;
                            d.line   = 1'b0;
                        end
                    end
                    LS_START: begin
                        if (q.sub == 4'd15) begin
                            d.state = LS_DATA;
                            d.sub   = '0;
                            d.bitn  = '0;
                            d.line  = q.shift[0];
                        end else begin
                            d.sub = q.sub + 1'b1;
                        end
                    end
                    LS_DATA: begin
                        if (q.sub == 4'd15) begin
                            d.sub = '0;
                            if (q.bitn == BW'(DW - 1)) begin
                                if (par_slot_used(par_mode)) begin
                                    d.state = LS_PAR;
                                    d.line  = q.pbit;
                                end else begin
                                    d.state = LS_STOP;
                                    d.line  = 1'b1;
                                end
                            end else begin
                                d.bitn  = q.bitn + 1'b1;
                                d.shift = q.shift >> 1;
                                d.line  = q.shift[1];
                            end
                        end else begin
                            d.sub = q.sub + 1'b1;
                        end
                    end
                    LS_PAR: begin
                        if (q.sub == 4'd15) begin
                            d.state = LS_STOP;
                            d.sub   = '0;
                            d.line  = 1'b1;
                        end else begin
                            d.sub = q.sub + 1'b1;
                        end
                    end
                    LS_STOP: begin
                        if (q.sub == 4'd15) begin
                            d.state = LS_IDLE;
                            d.sub   = '0;
                            d.line  = 1'b1;
                        end else begin
                            d.sub = q.sub + 1'b1;
                        end
                    end
                    default: begin
                        d.state = LS_IDLE;
                        d.line  = 1'b1;
                    end
                endcase
            end
            if (wr) begin
                d.hold   = wdata;
                d.hold_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= LS_IDLE;
            q.line  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line      = q.line;
    assign hold_full = q.hold_v;
    assign busy      = (q.state != LS_IDLE);
endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
    import dbg_uart_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        soft_rst,
    input  logic        tick,
    input  logic [2:0]  par_mode,
    input  logic        line_in,
    output logic        done,
    output logic [DW:0] data,
    output logic        frame_bad,
    output logic        par_bad,
    output logic        brk_in,
    output logic        brk_out
);
    localparam int BW = $clog2(DW);

    typedef struct packed {
        logic          s1;
        logic          s2;
        lstate_e       state;
        logic [3:0]    sub;
        logic [BW-1:0] bitn;
        logic [DW-1:0] shift;
        logic          zeros;
        logic          pbit;
        logic          done;
        logic [DW:0]   data;
        logic          fe;
        logic          pe;
        logic          bi;
        logic          bo;
    } st_t;

    st_t q, d;
    logic par_exp;

    always_comb begin
        case (par_mode)
            PAR_EVEN: par_exp = ^q.shift;
            PAR_ODD:  par_exp = ~^q.shift;
            PAR_MARK: par_exp = 1'b1;
            default:  par_exp = 1'b0;
        endcase
    end

    always_comb begin
        d = q;
        d.s1   = line_in;
        d.s2   = q.s1;
        d.done = 1'b0;
        d.fe   = 1'b0;
        d.pe   = 1'b0;
        d.bi   = 1'b0;
        d.bo   = 1'b0;
        if (!en || soft_rst) begin
            d.state = LS_IDLE;
            d.sub   = '0;
        end else if (tick) begin
            case (q.state)
                LS_IDLE: begin
                    if (!q.s2) begin
                        d.state = LS_START;
                        d.sub   = '0;
                    end
                end
                LS_START: begin
                    if (q.s2) begin
                        d.state = LS_IDLE;
                    end else if (q.sub == 4'd7) begin
                        d.state = LS_DATA;
                        d.sub   = '0;
                        d.bitn  = '0;
                        d.zeros = 1'b1;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                LS_DATA: begin
                    if (q.sub == 4'd15) begin
                        d.sub   = '0;
                        d.shift = {q.s2, q.shift[DW-1:1]};
                        d.zeros = q.zeros & ~q.s2;
                        if (q.bitn == BW'(DW - 1)) begin
                            d.state = par_slot_used(par_mode) ? LS_PAR : LS_STOP;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                LS_PAR: begin
                    if (q.sub == 4'd15) begin
                        d.sub   = '0;
                        d.pbit  = q.s2;
                        d.zeros = q.zeros & ~q.s2;
                        d.state = LS_STOP;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                LS_STOP: begin
                    if (q.sub == 4'd15) begin
                        d.sub = '0;
                        if (q.zeros && !q.s2) begin
                            d.state = LS_BRK;
                            d.bi    = 1'b1;
                        end else begin
                            d.state = LS_IDLE;
                            d.done  = 1'b1;
                            d.data  = {(par_mode == PAR_DROP) & q.pbit, q.shift};
                            d.fe    = ~q.s2;
                            d.pe    = par_checked(par_mode) && (q.pbit != par_exp);
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                LS_BRK: begin
                    if (q.s2) begin
                        d.state = LS_IDLE;
                        d.bo    = 1'b1;
                    end
                end
                default: d.state = LS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.s1    <= 1'b1;
            q.s2    <= 1'b1;
            q.state <= LS_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done      = q.done;
    assign data      = q.data;
    assign frame_bad = q.fe;
    assign par_bad   = q.pe;
    assign brk_in    = q.bi;
    assign brk_out   = q.bo;
endmodule

// File: rtl/dbg_uart.sv
module dbg_uart
    import dbg_uart_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             rxd,
    output logic             txd,
    output logic             irq
);
    typedef struct packed {
        logic             rx_en;
        logic             tx_en;
        logic [2:0]       par;
        logic [1:0]       chan;
        logic [DIV_W-1:0] div;
        logic [DW:0]      rx_hold;
        logic             rx_rdy;
        logic             ovr;
        logic             fe;
        logic             pe;
        logic             brk;
        logic [ST_W-1:0]  mask;
    } st_t;

    st_t q, d;

    logic [6:0]      cmd;
    logic            rd_rxh;
    logic            clr_cmd;
    logic            tick;
    logic            tx_line, tx_full, tx_busy;
    logic            rx_src;
    logic            rx_done, rx_fe, rx_pe, rx_bi, rx_bo;
    logic [DW:0]     rx_data;
    logic [ST_W-1:0] status;
    logic [1:0]      chan_w;
    logic            tx_en_w;

    assign cmd     = (bus_wr && bus_addr == ADR_CTRL) ? bus_wdata[6:0] : 7'd0;
    assign rd_rxh  = bus_rd && (bus_addr == ADR_RXH);
    assign clr_cmd = cmd[CMD_CLR];
    assign chan_w  = q.chan;
    assign tx_en_w = q.tx_en;

    dbg_uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (q.div),
        .tick  (tick)
    );

    dbg_uart_tx #(.DW(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (q.tx_en),
        .soft_rst  (cmd[CMD_TX_RST]),
        .tick      (tick),
        .par_mode  (q.par),
        .wr        (bus_wr && bus_addr == ADR_TXH),
        .wdata     (bus_wdata[DW:0]),
        .line      (tx_line),
        .hold_full (tx_full),
        .busy      (tx_busy)
    );

    dbg_uart_rx #(.DW(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (q.rx_en),
        .soft_rst  (cmd[CMD_RX_RST]),
        .tick      (tick),
        .par_mode  (q.par),
        .line_in   (rx_src),
        .done      (rx_done),
        .data      (rx_data),
        .frame_bad (rx_fe),
        .par_bad   (rx_pe),
        .brk_in    (rx_bi),
        .brk_out   (rx_bo)
    );

    // pin routing
    always_comb begin
        case (q.chan)
            CH_ECHO:   begin rx_src = rxd;     txd = rxd;     end
            CH_LOCAL:  begin rx_src = tx_line; txd = 1'b1;    end
            CH_REMOTE: begin rx_src = 1'b1;    txd = rxd;     end
            default:   begin rx_src = rxd;     txd = tx_line; end
        endcase
    end

    always_comb begin
        status           = '0;
        status[ST_RXRDY] = q.rx_rdy;
        status[ST_TXRDY] = q.tx_en & ~tx_full;
        status[ST_BRK]   = q.brk;
        status[ST_OVR]   = q.ovr;
        status[ST_FRM]   = q.fe;
        status[ST_PAR]   = q.pe;
        status[ST_TXEMP] = q.tx_en & ~tx_full & ~tx_busy;
    end

    assign irq = |(status & q.mask);

    always_comb begin
        case (bus_addr)
            ADR_MODE: bus_rdata = BUS_W'({q.chan, 1'b0, q.par});
            ADR_DIV:  bus_rdata = BUS_W'(q.div);
            ADR_RXH:  bus_rdata = BUS_W'(q.rx_hold);
            ADR_IEN:  bus_rdata = BUS_W'(q.mask);
            ADR_STAT: bus_rdata = BUS_W'(status);
            default:  bus_rdata = '0;
        endcase
    end

    always_comb begin
        d = q;
        if (cmd[CMD_RX_OFF])     d.rx_en = 1'b0;
        else if (cmd[CMD_RX_ON]) d.rx_en = 1'b1;
        if (cmd[CMD_TX_OFF])     d.tx_en = 1'b0;
        else if (cmd[CMD_TX_ON]) d.tx_en = 1'b1;
        if (bus_wr && bus_addr == ADR_MODE) begin
            d.par  = bus_wdata[2:0];
            d.chan = bus_wdata[5:4];
        end
        if (bus_wr && bus_addr == ADR_DIV)  d.div  = bus_wdata[DIV_W-1:0];
        if (bus_wr && bus_addr == ADR_IEN)  d.mask = q.mask | bus_wdata[ST_W-1:0];
        if (bus_wr && bus_addr == ADR_IDIS) d.mask = q.mask & ~bus_wdata[ST_W-1:0];
        if (clr_cmd) begin
            d.ovr = 1'b0;
            d.fe  = 1'b0;
            d.pe  = 1'b0;
            d.brk = 1'b0;
        end
        if (rd_rxh) d.rx_rdy = 1'b0;
        if (rx_done) begin
            if (q.rx_rdy && !rd_rxh) d.ovr = 1'b1;
            d.rx_hold = rx_data;
            d.rx_rdy  = 1'b1;
            if (rx_fe) d.fe = 1'b1;
            if (rx_pe) d.pe = 1'b1;
        end
        if (rx_bi || rx_bo) d.brk = 1'b1;
        if (cmd[CMD_RX_RST]) d.rx_rdy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dbg_uart_chk.sv
module dbg_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_rxh,
    input logic       clr_cmd,
    input logic       rx_done,
    input logic       txd,
    input logic [1:0] chan,
    input logic       tx_en,
    input logic [6:0] status
);
    // R7
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxh && !rx_done) |=> !status[0]);

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && status[0] && !rd_rxh) |=> status[3]);

    // R11
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[3]) |-> $past(clr_cmd));

    // R11
    brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[2]) |-> $past(clr_cmd));

    // R6
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> status[1]);

    // R1
    tx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan == 2'd0 && $past(chan) == 2'd0 && !tx_en && !$past(tx_en)) |-> txd);
endmodule

bind dbg_uart dbg_uart_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_rxh  (rd_rxh),
    .clr_cmd (clr_cmd),
    .rx_done (rx_done),
    .txd     (txd),
    .chan    (chan_w),
    .tx_en   (tx_en_w),
    .status  (status)
);

// File: tb/sim_dbg_uart.sv
module sim_dbg_uart;
    import dbg_uart_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = ADR_STAT;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;
    logic        irq;

    always #10 clk = ~clk;

    dbg_uart u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    int cd     = 1;
    bit finished = 0;

    // behavioural model: expected received characters queue
    int exp_rx[$];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit ref_par(input int m, input logic [7:0] v, input bit flag);
        case (m)
            1: return ^v;
            2: return ~^v;
            4: return 1'b1;
            5: return flag;
            default: return 1'b0;
        endcase
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = ADR_STAT;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = ADR_STAT;
    endtask

    task automatic stat(output logic [6:0] s);
        logic [15:0] v;
        rd(ADR_STAT, v);
        s = v[6:0];
    endtask

    task automatic rx_frame(input logic [7:0] v, input bit use_p, input bit p, input bit stp);
        int per;
        per = 16 * cd;
        rxd = 1'b0; repeat (per) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = v[i]; repeat (per) @(negedge clk);
        end
        if (use_p) begin
            rxd = p; repeat (per) @(negedge clk);
        end
        rxd = stp; repeat (per) @(negedge clk);
        rxd = 1'b1; repeat (2 * per) @(negedge clk);
    endtask

    task automatic cap_tx(input bit use_p, output logic [7:0] v, output bit p,
                          output bit stp, output logic [6:0] mid);
        int per, t;
        per = 16 * cd;
        t = 0;
        v = '0; p = 1'b0; stp = 1'b0; mid = '0;
        while (txd !== 1'b0 && t < 5000) begin
            @(negedge clk); t++;
        end
        chk("R3 start bit seen", int'(t < 5000), 1);
        repeat (per / 2) @(negedge clk);
        mid = bus_rdata[6:0];
        chk("R3 start bit level", int'(txd), 0);
        for (int i = 0; i < 8; i++) begin
            repeat (per) @(negedge clk);
            v[i] = txd;
        end
        if (use_p) begin
            repeat (per) @(negedge clk);
            p = txd;
        end
        repeat (per) @(negedge clk);
        stp = txd;
        repeat (per) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        logic [6:0]  s, mid;
        logic [7:0]  dv;
        bit          pb, sb;
        int          lowc, bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        stat(s);
        chk("R1 reset status", int'(s), 0);
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset irq", int'(irq), 0);

        // R2 divisor zero halts transmitter
        wr(ADR_DIV, 16'd0);
        wr(ADR_CTRL, 16'h0010);
        stat(s);
        chk("R6 tx ready and empty when idle", int'({s[6], s[1]}), 3);
        wr(ADR_TXH, 16'h0055);
        bad = 0;
        repeat (100) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        chk("R2 zero divisor keeps line idle", bad, 0);
        stat(s);
        chk("R2 zero divisor keeps char held", int'(s[1]), 0);

        // R3 frame with no parity, R6 mid-frame status
        cd = 1;
        wr(ADR_DIV, 16'd1);
        cap_tx(1'b0, dv, pb, sb, mid);
        chk("R3 data bits", int'(dv), 'h55);
        chk("R3 stop bit", int'(sb), 1);
        chk("R6 ready while shifting", int'(mid[1]), 1);
        chk("R6 not empty while shifting", int'(mid[6]), 0);
        repeat (40) @(negedge clk);
        stat(s);
        chk("R6 empty after frame", int'(s[6]), 1);

        // R2 bit time with divisor 3
        wr(ADR_DIV, 16'd3);
        wr(ADR_TXH, 16'h0001);
        while (txd !== 1'b0) @(negedge clk);
        lowc = 0;
        while (txd === 1'b0) begin
            lowc++; @(negedge clk);
        end
        chk("R2 start bit length 16*CD", lowc, 48);
        repeat (16 * 3 * 11) @(negedge clk);
        wr(ADR_DIV, 16'd1);
        repeat (40) @(negedge clk);

        // R4 parity modes
        for (int m = 1; m <= 4; m++) begin
            wr(ADR_MODE, 16'(m));
            wr(ADR_TXH, 16'h0035);
            cap_tx(1'b1, dv, pb, sb, mid);
            chk($sformatf("R4 parity mode %0d", m), int'(pb), int'(ref_par(m, 8'h35, 1'b0)));
            chk("R3 data under parity", int'(dv), 'h35);
        end
        wr(ADR_MODE, 16'(1));
        wr(ADR_TXH, 16'h0007);
        cap_tx(1'b1, dv, pb, sb, mid);
        chk("R4 even parity odd count", int'(pb), 1);

        // R5 multidrop flag on transmit
        wr(ADR_MODE, 16'(5));
        wr(ADR_TXH, 16'h01A5);
        cap_tx(1'b1, dv, pb, sb, mid);
        chk("R5 address flag set", int'(pb), 1);
        wr(ADR_TXH, 16'h00A5);
        cap_tx(1'b1, dv, pb, sb, mid);
        chk("R5 address flag clear", int'(pb), 0);
        repeat (40) @(negedge clk);

        // R13 local loopback with R5 receive flag
        wr(ADR_MODE, 16'h0025);
        wr(ADR_CTRL, 16'h0004);
        exp_rx.push_back('h1C3);
        wr(ADR_TXH, 16'h01C3);
        bad = 0;
        repeat (260) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        chk("R13 local loopback keeps txd high", bad, 0);
        stat(s);
        chk("R7 loopback char ready", int'(s[0]), 1);
        chk("R5 no parity error in multidrop", int'(s[5]), 0);
        rd(ADR_RXH, v);
        chk("R5 receive flag in bit 8", int'(v), exp_rx.pop_front());
        stat(s);
        chk("R7 read clears ready", int'(s[0]), 0);

        // R7 normal receive
        wr(ADR_MODE, 16'h0000);
        exp_rx.push_back('hA7);
        rx_frame(8'hA7, 1'b0, 1'b0, 1'b1);
        stat(s);
        chk("R7 ready after frame", int'(s[0]), 1);
        chk("R9 no framing error on good frame", int'(s[4]), 0);
        rd(ADR_RXH, v);
        chk("R7 received value", int'(v), exp_rx.pop_front());

        // R8 overrun
        rx_frame(8'h10, 1'b0, 1'b0, 1'b1);
        rx_frame(8'h20, 1'b0, 1'b0, 1'b1);
        stat(s);
        chk("R8 overrun flag", int'(s[3]), 1);
        rd(ADR_RXH, v);
        chk("R8 newest char kept", int'(v), 'h20);
        stat(s);
        chk("R11 overrun sticky after read", int'(s[3]), 1);
        wr(ADR_CTRL, 16'h0040);
        stat(s);
        chk("R11 clear command", int'(s[5:2]), 0);

        // R9 framing error
        rx_frame(8'h3C, 1'b0, 1'b0, 1'b0);
        stat(s);
        chk("R9 framing error", int'(s[4]), 1);
        chk("R11 not a break", int'(s[2]), 0);
        rd(ADR_RXH, v);
        chk("R9 char still delivered", int'(v), 'h3C);
        wr(ADR_CTRL, 16'h0040);

        // R10 parity error
        wr(ADR_MODE, 16'h0001);
        rx_frame(8'h35, 1'b1, 1'b1, 1'b1);
        stat(s);
        chk("R10 even parity mismatch", int'(s[5]), 1);
        rd(ADR_RXH, v);
        wr(ADR_CTRL, 16'h0040);
        rx_frame(8'h35, 1'b1, 1'b0, 1'b1);
        stat(s);
        chk("R10 correct parity no error", int'(s[5]), 0);
        rd(ADR_RXH, v);
        wr(ADR_MODE, 16'h0000);

        // R11 break entry and exit
        rxd = 1'b0;
        repeat (16 * 12) @(negedge clk);
        stat(s);
        chk("R11 break on entry", int'(s[2]), 1);
        chk("R11 break delivers no char", int'(s[0]), 0);
        wr(ADR_CTRL, 16'h0040);
        stat(s);
        chk("R11 break cleared while low", int'(s[2]), 0);
        rxd = 1'b1;
        repeat (16 * 3) @(negedge clk);
        stat(s);
        chk("R11 break set again on exit", int'(s[2]), 1);
        wr(ADR_CTRL, 16'h0040);

        // R12 glitch rejection
        rxd = 1'b0; repeat (4) @(negedge clk);
        rxd = 1'b1; repeat (16 * 20) @(negedge clk);
        stat(s);
        chk("R12 glitch ignored", int'({s[5:2], s[0]}), 0);

        // R13 echo
        wr(ADR_MODE, 16'h0010);
        @(negedge clk);
        rxd = 1'b0; #1;
        chk("R13 echo copies rxd", int'(txd), 0);
        rxd = 1'b1; #1;
        chk("R13 echo copies rxd high", int'(txd), 1);
        rx_frame(8'h5A, 1'b0, 1'b0, 1'b1);
        rd(ADR_RXH, v);
        chk("R13 echo still receives", int'(v), 'h5A);

        // R13 remote loopback
        wr(ADR_MODE, 16'h0030);
        @(negedge clk);
        rxd = 1'b0; #1;
        chk("R13 remote copies rxd", int'(txd), 0);
        rxd = 1'b1;
        rx_frame(8'h66, 1'b0, 1'b0, 1'b1);
        stat(s);
        chk("R13 remote receiver idle", int'(s[0]), 0);

        // R14 interrupt mask
        wr(ADR_MODE, 16'h0000);
        rx_frame(8'h11, 1'b0, 1'b0, 1'b1);
        chk("R14 masked no irq", int'(irq), 0);
        wr(ADR_IEN, 16'h0001);
        chk("R14 unmasked irq", int'(irq), 1);
        rd(ADR_IEN, v);
        chk("R14 mask readback", int'(v), 1);
        wr(ADR_IDIS, 16'h0001);
        chk("R14 mask cleared", int'(irq), 0);
        rd(ADR_RXH, v);

        // R1 transmitter disable ignores writes
        wr(ADR_CTRL, 16'h0020);
        wr(ADR_TXH, 16'h0099);
        bad = 0;
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        chk("R1 disabled tx stays idle", bad, 0);
        wr(ADR_CTRL, 16'h0010);
        stat(s);
        chk("R1 write while disabled dropped", int'(s[6]), 1);

        // R1 disable wins, receiver off, receiver reset
        wr(ADR_CTRL, 16'h000C);
        rx_frame(8'h42, 1'b0, 1'b0, 1'b1);
        stat(s);
        chk("R1 off wins over on", int'(s[0]), 0);
        wr(ADR_CTRL, 16'h0004);
        rx_frame(8'h42, 1'b0, 1'b0, 1'b1);
        stat(s);
        chk("R1 receiver back on", int'(s[0]), 1);
        wr(ADR_CTRL, 16'h0001);
        stat(s);
        chk("R1 receiver reset clears ready", int'(s[0]), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule